// File: doc/BRIEF.md
# Quasi-resonant valley counter with timeout insertion

This block sits in the turn-on path of a quasi-resonant flyback controller. After the power switch turns off, the drain voltage rings. A digitised zero-crossing comparator marks each dip of that ringing. The block counts those dips (the valleys) and raises a turn-on request when the count reaches the valley chosen by the load-dependent selection logic: the first, second, third or fourth.

Right after turn-off, leakage ringing would produce false crossings, so comparator activity is ignored for a fixed blanking interval. When the ringing is so damped that the comparator stops toggling, a retriggerable timeout supplies the missing valleys. Each time no comparator transition has been seen for a fixed interval, it injects a synthetic valley. It re-arms after each injection, so the count still reaches the selected valley. All intervals are parameters counted in clock cycles. The comparator input passes through a synchroniser, so it may be asynchronous.

Top module: `qr_valley_sequencer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `valley_cnt_o` is 0 and `turn_on_o` is 0.
- R2: On any clock edge that samples `gate_on_i` high, the count is cleared to 0, and `turn_on_o` is low after that edge.
- R3: A comparator fall is ignored if its effective edge lies within `BLANK_CYC` edges of turn-off. Edge 0 is the first edge that samples `gate_on_i` low, and the ignored edges are 0 to `BLANK_CYC`-1. The timeout timer is held at zero over the same edges.
- R4: A 1-to-0 transition of `zcd_i` adds one to the count. If `zcd_i` is first sampled low at edge N, the count changes after edge N+2, because of the two synchroniser flops plus one edge-detect register.
- R5: If no `zcd_i` transition (either direction) takes effect for `TMO_CYC` consecutive edges after blanking ends, one synthetic valley is counted. The first one lands on edge `BLANK_CYC+TMO_CYC-1`.
- R6: The timeout restarts after every synthetic valley. With no further transitions, synthetic valleys follow every `TMO_CYC` edges.
- R7: A synthetic valley opens a merge window of `PULSE_CYC` edges, starting with its own edge. A real fall whose effective edge falls inside this window is absorbed, so together they count once. A real fall on the same edge as the synthetic valley is likewise counted once.
- R8: The count saturates at `MAX_VALLEY` (4).
- R9: `valley_sel_i` value v selects valley v+1 (0 selects the 1st, 3 the 4th). After each edge, `turn_on_o` is 1 exactly when the count after that edge equals the selection sampled at that edge plus one.
- R10: A 0-to-1 transition of `zcd_i` never changes the count, but it restarts the timeout like any transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_on_i | input | 1 | Gate drive state, 1 while the switch is on |
| zcd_i | input | 1 | Raw zero-crossing comparator output, falls at each valley |
| valley_sel_i | input | 2 | Selected valley minus one |
| turn_on_o | output | 1 | Registered turn-on request |
| valley_cnt_o | output | 3 | Registered valley count, 0 to 4 |

## Verification
A level change on `zcd_i` first sampled at edge N affects the count and the request after edge N+2. Synthetic valleys and gate clears show up after the very edge on which they are decided. The bench fixes turn-off as edge 0 and gives every edge of the observation window its own precomputed expected count and request, derived from the requirement timings above. It drives inputs and samples outputs on the falling clock edge, so each comparison reads the result of exactly one rising edge. Directed windows put real falls on and just after a timeout edge, only inside blanking, or only as rising edges. Random windows vary start, half-period and the number of ring transitions before the ringing dies.

// File: rtl/qrv_pkg.sv
package qrv_pkg;

  // Width able to hold values 0 .. n-1 (at least one bit)
  function automatic int bits_for(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Source of a counted valley in one cycle
  typedef struct packed {
    logic synth;
    logic real_fall;
  } valley_src_t;

endpackage

// File: rtl/qrv_sync_edge.sv
module qrv_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall,
  output logic toggled
);

  // pipe[STAGES-1:0] synchroniser, pipe[STAGES] history for edge detect
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-1:0], din};
  end

  assign fall    = pipe[STAGES] & ~pipe[STAGES-1];
  assign toggled = pipe[STAGES] ^ pipe[STAGES-1];

endmodule

// File: rtl/qrv_blank_timer.sv
module qrv_blank_timer #(
  parameter int BLANK_CYC = 600
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_on,
  output logic busy
);

  localparam int BW = qrv_pkg::bits_for(BLANK_CYC + 1);

  logic [BW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)             left <= '0;
    else if (gate_on)    left <= BW'(BLANK_CYC);
    else if (left != '0) left <= left - BW'(1);
  end

  assign busy = gate_on | (left != '0);

endmodule

// File: rtl/qrv_timeout_gen.sv
module qrv_timeout_gen #(
  parameter int TMO_CYC   = 1050,
  parameter int PULSE_CYC = 20
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  hold,
  input  logic                                  zcd_toggled,
  input  logic                                  zcd_fall,
  output qrv_pkg::valley_src_t                  src,
  output logic [qrv_pkg::bits_for(TMO_CYC)-1:0] tmo_level
);

  localparam int TW = qrv_pkg::bits_for(TMO_CYC);
  localparam int PW = qrv_pkg::bits_for(PULSE_CYC);

  logic [TW-1:0] tmo_cnt;
  logic [PW-1:0] merge_left;
  logic          fire;
  logic          real_ok;

  always_comb begin
    fire    = !hold && (tmo_cnt == TW'(TMO_CYC - 1));
    real_ok = zcd_fall && !hold && (merge_left == '0);
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      tmo_cnt    <= '0;
      merge_left <= '0;
    end else begin
      tmo_cnt <= (zcd_toggled || fire) ? '0 : tmo_cnt + TW'(1);
      if (fire)                  merge_left <= PW'(PULSE_CYC - 1);
      else if (merge_left != '0) merge_left <= merge_left - PW'(1);
    end
  end

  assign src.synth     = fire;
  assign src.real_fall = real_ok;
  assign tmo_level     = tmo_cnt;

endmodule

// File: rtl/qrv_valley_cnt.sv
module qrv_valley_cnt #(
  parameter int MAX_VALLEY = 4
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         clr,
  input  qrv_pkg::valley_src_t                         src,
  input  logic [qrv_pkg::bits_for(MAX_VALLEY)-1:0]     sel,
  output logic [qrv_pkg::bits_for(MAX_VALLEY+1)-1:0]   cnt,
  output logic                                         hit
);

  localparam int CW = qrv_pkg::bits_for(MAX_VALLEY + 1);

  logic [CW-1:0] cnt_nxt;
  logic          step;

  always_comb begin
    step = src.synth | src.real_fall;
    if (clr)                                cnt_nxt = '0;
    else if (step && cnt != CW'(MAX_VALLEY)) cnt_nxt = cnt + CW'(1);
    else                                    cnt_nxt = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      hit <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      hit <= (32'(cnt_nxt) == 32'(sel) + 32'd1);
    end
  end

endmodule

// File: rtl/qr_valley_sequencer.sv
module qr_valley_sequencer #(
  parameter int BLANK_CYC   = 600,
  parameter int TMO_CYC     = 1050,
  parameter int PULSE_CYC   = 20,
  parameter int MAX_VALLEY  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       gate_on_i,
  input  logic       zcd_i,
  input  logic [1:0] valley_sel_i,
  output logic       turn_on_o,
  output logic [2:0] valley_cnt_o
);

  localparam int SEL_W = qrv_pkg::bits_for(MAX_VALLEY);
  localparam int CNT_W = qrv_pkg::bits_for(MAX_VALLEY + 1);
  localparam int TMO_W = qrv_pkg::bits_for(TMO_CYC);

  logic                 zcd_fall;
  logic                 zcd_toggled;
  logic                 blank_busy;
  qrv_pkg::valley_src_t src;
  logic [TMO_W-1:0]     tmo_level;
  logic [CNT_W-1:0]     cnt;

  qrv_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .din(zcd_i),
    .fall(zcd_fall), .toggled(zcd_toggled)
  );

  qrv_blank_timer #(.BLANK_CYC(BLANK_CYC)) i_blank (
    .clk(clk), .rst(rst), .gate_on(gate_on_i), .busy(blank_busy)
  );

  qrv_timeout_gen #(.TMO_CYC(TMO_CYC), .PULSE_CYC(PULSE_CYC)) i_tmo (
    .clk(clk), .rst(rst), .hold(blank_busy),
    .zcd_toggled(zcd_toggled), .zcd_fall(zcd_fall),
    .src(src), .tmo_level(tmo_level)
  );

  qrv_valley_cnt #(.MAX_VALLEY(MAX_VALLEY)) i_cnt (
    .clk(clk), .rst(rst), .clr(gate_on_i), .src(src),
    .sel(SEL_W'(valley_sel_i)), .cnt(cnt), .hit(turn_on_o)
  );

  assign valley_cnt_o = 3'(cnt);

endmodule

// File: rtl/qrv_checker.sv
module qrv_checker #(
  parameter int MAX_VALLEY = 4,
  parameter int TMO_CYC    = 1050,
  parameter int TW         = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          gate_on_i,
  input logic          blank_busy,
  input logic [1:0]    valley_sel_i,
  input logic          turn_on_o,
  input logic [2:0]    valley_cnt_o,
  input logic [TW-1:0] tmo_level
);

  // R2
  gate_clear_chk: assert property (@(posedge clk) disable iff (rst)
    gate_on_i |=> (valley_cnt_o == 3'd0 && !turn_on_o));

  // R8
  sat_bound_chk: assert property (@(posedge clk) disable iff (rst)
    32'(valley_cnt_o) <= MAX_VALLEY);

  // R4
  step_one_chk: assert property (@(posedge clk) disable iff (rst)
    !gate_on_i |=> (valley_cnt_o == $past(valley_cnt_o) ||
                    valley_cnt_o == $past(valley_cnt_o) + 3'd1));

  // R3
  blank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!gate_on_i && blank_busy) |=> $stable(valley_cnt_o));

  // R9
  request_match_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (turn_on_o == (32'(valley_cnt_o) == 32'($past(valley_sel_i)) + 32'd1)));

  // R5
  tmo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    32'(tmo_level) < TMO_CYC);

  // R6
  tmo_rearm_chk: assert property (@(posedge clk) disable iff (rst)
    (!blank_busy && 32'(tmo_level) == TMO_CYC - 1) |=> tmo_level == '0);

endmodule

bind qr_valley_sequencer qrv_checker #(
  .MAX_VALLEY(MAX_VALLEY), .TMO_CYC(TMO_CYC), .TW(TMO_W)
) i_qrv_checker (
  .clk(clk), .rst(rst), .gate_on_i(gate_on_i), .blank_busy(blank_busy),
  .valley_sel_i(valley_sel_i), .turn_on_o(turn_on_o),
  .valley_cnt_o(valley_cnt_o), .tmo_level(tmo_level)
);

// File: tb/test_qr_valley_sequencer.sv
`timescale 1ns/1ps
module test_qr_valley_sequencer;

  localparam int B  = 10;
  localparam int T  = 16;
  localparam int P  = 3;
  localparam int MX = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       gate = 1'b0;
  logic       zcd = 1'b1;
  logic [1:0] vsel = 2'd0;
  logic       turn_on_o;
  logic [2:0] valley_cnt_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  logic raw     [0:511];
  int   exp_cnt [0:511];
  logic exp_on  [0:511];

  always #2.5 clk = ~clk;

  qr_valley_sequencer #(
    .BLANK_CYC(B), .TMO_CYC(T), .PULSE_CYC(P), .MAX_VALLEY(MX), .SYNC_STAGES(2)
  ) i_qr_valley_sequencer (
    .clk(clk), .rst(rst), .gate_on_i(gate), .zcd_i(zcd),
    .valley_sel_i(vsel), .turn_on_o(turn_on_o), .valley_cnt_o(valley_cnt_o)
  );

  // Expected outputs per edge k after turn-off, from R3..R10 timings
  function automatic void build_model(input int sel, input int w);
    int t = 0, pc = 0, c = 0;
    for (int k = 0; k < w; k++) begin
      logic r3, r2, fall, tog, fire, ev;
      r3   = (k >= 3) ? raw[k-3] : 1'b1;
      r2   = (k >= 2) ? raw[k-2] : 1'b1;
      fall = r3 & ~r2;             // R4: effective two edges after first low sample
      tog  = r3 ^ r2;              // R10: any transition restarts timeout
      if (k < B) begin             // R3
        ev = 1'b0; t = 0; pc = 0;
      end else begin
        fire = (t == T - 1);       // R5
        ev   = fire | (fall & (pc == 0));   // R7
        t    = (tog | fire) ? 0 : t + 1;     // R6
        pc   = fire ? P - 1 : ((pc > 0) ? pc - 1 : 0);
      end
      if (ev && c < MX) c++;       // R8
      exp_cnt[k] = c;
      exp_on[k]  = (c == sel + 1); // R9
    end
  endfunction

  task automatic check_out(input string tag, input int k, input int ecnt, input logic eon);
    n_chk++;
    if (int'(valley_cnt_o) != ecnt || turn_on_o !== eon) begin
      n_bad++;
      $display("FAIL %s edge %0d: cnt=%0d on=%0b expected cnt=%0d on=%0b",
               tag, k, valley_cnt_o, turn_on_o, ecnt, eon);
    end
  endtask

  task automatic run_window(input string tag, input int sel, input int w);
    build_model(sel, w);
    @(negedge clk);
    gate = 1'b1; zcd = 1'b1; vsel = 2'(sel);
    repeat (5) begin
      @(negedge clk);
      check_out({tag, " R2 gate-on"}, -1, 0, 1'b0);
    end
    gate = 1'b0; zcd = raw[0];
    for (int k = 0; k < w; k++) begin
      @(negedge clk);
      check_out(tag, k, exp_cnt[k], exp_on[k]);
      if (k + 1 < w) zcd = raw[k+1];
    end
  endtask

  initial begin
    int w;
    void'($urandom(32'd24681));
    // R1 reset state
    repeat (3) @(negedge clk);
    check_out("R1 in reset", -1, 0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check_out("R1 after release", -1, 0, 1'b0);

    // R5 R6 R8: no ringing at all, timeouts only, then saturation
    w = B + 5*T + 4;
    for (int i = 0; i < w; i++) raw[i] = 1'b1;
    run_window("R5 R6 R8 timeout-only", 3, w);

    // R4 R9: clean ringing, second valley selected
    w = B + 4*T;
    for (int i = 0; i < w; i++) raw[i] = (i < B) ? 1'b1 : (((i - B) / 3) % 2 == 0);
    run_window("R4 R9 clean ring", 1, w);

    // R3: ringing only inside blanking
    w = B + 2*T;
    for (int i = 0; i < w; i++) raw[i] = (i <= B - 4) ? ((i / 2) % 2 == 1) : 1'b1;
    run_window("R3 blank-only ring", 0, w);

    // R7: real fall on the timeout edge
    w = B + 3*T;
    for (int i = 0; i < w; i++) raw[i] = (i < B + T - 3);
    run_window("R7 same-edge merge", 0, w);

    // R7: real fall one edge after the timeout edge
    for (int i = 0; i < w; i++) raw[i] = (i < B + T - 2);
    run_window("R7 window merge", 1, w);

    // R10: only a rising edge after blanking
    for (int i = 0; i < w; i++) raw[i] = (i >= B + 2);
    run_window("R10 rise-only", 3, w);

    // Random damped ringing
    for (int trial = 0; trial < 40; trial++) begin
      int s, h, n, sel, nt;
      logic lvl;
      s   = $urandom_range(B + 6, 0);
      h   = $urandom_range(8, 2);
      n   = $urandom_range(9, 0);
      sel = $urandom_range(3, 0);
      w   = B + 6*T;
      lvl = 1'b1; nt = 0;
      for (int i = 0; i < w; i++) begin
        if (i >= s && nt < n && ((i - s) % h) == 0) begin
          lvl = ~lvl; nt++;
        end
        raw[i] = lvl;
      end
      run_window("R3 R4 R5 R7 R9 random", sel, w);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: finished=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule